// File: doc/BRIEF.md
# Sync-Referenced Plane-Reset Timestamp Recorder

This block measures how closely a group of micromirror array drivers stay aligned with each other. It counts the frame synchronisation pulses it receives. It also runs a fine interval counter that starts again from zero at every pulse. Each time a bit-plane reset command is issued for one of the low-order planes, the block takes a timestamp: the current frame number, the time elapsed since the last sync and the plane index. The timestamp goes into a small record buffer.

Each board keeps its own recorder. Software on each side reads the records out through a show-ahead read port. Because every stamp is taken relative to the same sync pulse, the logs from different boards can be lined up frame by frame. The interval counter advances on a prescaled tick of the system clock and stops at its maximum value instead of wrapping. The buffer keeps the oldest records when it fills. Any capture that arrives while the buffer is full is discarded, and a sticky flag records that this happened.

Top module: `plane_reset_stamper`

## Requirements
- R1: During and right after reset the buffer is empty (`empty_o`=1, `full_o`=0) and `overflow_o`=0. The frame count and the interval count are both zero.
- R2: The frame count rises by one at every clock edge where `sync_i` is high, and wraps modulo 2^SYNC_W. A stored record's frame field holds the number of sync pulses sampled up to and including the capture edge.
- R3: The prescaler and the interval count are cleared at every sync edge (and at reset). After that, the interval count rises by one every PRESCALE clocks. A capture sampled k clocks after a sync edge therefore stores the offset floor((k-1)/PRESCALE).
- R4: The interval count saturates at 2^IVL_W-1 and never wraps to zero until the next sync.
- R5: A capture happens only on an edge where `rst_strobe_i`=1 and `plane_i` < CAP_PLANES (default 4). A strobe for any higher plane stores nothing.
- R6: Each record holds the fields frame, offset and plane. Records are read out oldest first. When `empty_o`=0, `rd_frame_o`, `rd_offset_o` and `rd_plane_o` show the oldest record.
- R7: When `sync_i` and a qualifying strobe fall on the same edge, the record stores offset 0 and the already-incremented frame count.
- R8: The buffer holds DEPTH (default 8) records and raises `full_o` when it holds that many. A capture on an edge where `full_o` is high is dropped, and `overflow_o` becomes 1. `overflow_o` stays at 1 until reset.
- R9: `rd_en_i`=1 while the buffer is not empty removes the oldest record. `rd_en_i`=1 while the buffer is empty has no effect. A capture and a read on the same edge of a non-full buffer both take effect.
- R10: Fullness is judged at the start of the cycle. A capture on an edge where the buffer is full and `rd_en_i`=1 is still dropped, while the read removes one record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_i | input | 1 | Frame sync pulse, one clock wide |
| rst_strobe_i | input | 1 | Bit-plane reset command strobe |
| plane_i | input | PLANE_W | Index of the plane being reset |
| rd_en_i | input | 1 | Remove the oldest record |
| rd_frame_o | output | SYNC_W | Frame field of the oldest record |
| rd_offset_o | output | IVL_W | Offset field of the oldest record |
| rd_plane_o | output | PLANE_W | Plane field of the oldest record |
| empty_o | output | 1 | Buffer holds no record |
| full_o | output | 1 | Buffer holds DEPTH records |
| overflow_o | output | 1 | Sticky: a capture was dropped |

## Verification
Two pairs of events can land on the same clock edge.

The first pair is a sync pulse and a qualifying reset strobe. The bench drives both high in the same cycle and expects a record with offset zero and the already-advanced frame number.

The second pair is a capture and a read. The bench raises both on a partly filled buffer and expects the occupancy to stay unchanged. It then raises both on a full buffer and expects the read to take effect and the capture to be dropped with the overflow flag set. A behavioural queue model judges every cycle.

// File: rtl/stamp_pkg.sv
// Package: shared constants and types for the plane-reset timestamp recorder.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package stamp_pkg;

    // Default field widths and sizes shared by the recorder modules.
    localparam int unsigned DEF_SYNC_W     = 16;
    localparam int unsigned DEF_IVL_W      = 16;
    localparam int unsigned DEF_PRESCALE   = 4;
    localparam int unsigned DEF_PLANE_W    = 3;
    localparam int unsigned DEF_DEPTH      = 8;
    localparam int unsigned DEF_CAP_PLANES = 4;

    // Buffer operation selected in a cycle.
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_BOTH = 2'b11
    } buf_op_e;

endpackage

// File: rtl/stamp_timebase.sv
// Module: stamp_timebase
// Counts sync pulses and keeps an interval counter that restarts at each
// sync. The interval counter advances on a prescaled tick and saturates.
// Assumes: sync_i is a single-cycle pulse synchronous to clk.
module stamp_timebase #(
    parameter int unsigned SYNC_W   = stamp_pkg::DEF_SYNC_W,
    parameter int unsigned IVL_W    = stamp_pkg::DEF_IVL_W,
    parameter int unsigned PRESCALE = stamp_pkg::DEF_PRESCALE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    output logic [SYNC_W-1:0] sync_cnt_o,
    output logic [IVL_W-1:0]  ivl_o
);

    localparam int unsigned PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PS_W-1:0]  PS_LAST = PS_W'(PRESCALE - 1);
    localparam logic [IVL_W-1:0] IVL_MAX = '1;

    logic [PS_W-1:0]   presc_q;
    logic              tick;
    logic [SYNC_W-1:0] sync_cnt_q;
    logic [IVL_W-1:0]  ivl_q;

    // Tick fires on the last prescaler count.
    always_comb begin
        tick = (presc_q == PS_LAST);
    end

    // Prescaler: restarts on sync, wraps after PRESCALE clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
        end else if (sync_i || tick) begin
            presc_q <= '0;
        end else begin
            presc_q <= presc_q + 1'b1;
        end
    end

    // Sync counter: one step per received pulse, wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_cnt_q <= '0;
        end else if (sync_i) begin
            sync_cnt_q <= sync_cnt_q + 1'b1;
        end
    end

    // Interval counter: cleared by sync, saturating increment on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ivl_q <= '0;
        end else if (sync_i) begin
            ivl_q <= '0;
        end else if (tick && (ivl_q != IVL_MAX)) begin
            ivl_q <= ivl_q + 1'b1;
        end
    end

    assign sync_cnt_o = sync_cnt_q;
    assign ivl_o      = ivl_q;

endmodule

// File: rtl/stamp_capture.sv
// Module: stamp_capture
// Qualifies reset strobes by plane index, forms the record
// {plane, frame, offset} and decides push or drop. Holds the sticky
// overflow flag.
// Assumes: full_i reflects occupancy at the start of the cycle.
module stamp_capture #(
    parameter int unsigned SYNC_W     = stamp_pkg::DEF_SYNC_W,
    parameter int unsigned IVL_W      = stamp_pkg::DEF_IVL_W,
    parameter int unsigned PLANE_W    = stamp_pkg::DEF_PLANE_W,
    parameter int unsigned CAP_PLANES = stamp_pkg::DEF_CAP_PLANES,
    localparam int unsigned REC_W     = SYNC_W + IVL_W + PLANE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_i,
    input  logic               strobe_i,
    input  logic [PLANE_W-1:0] plane_i,
    input  logic [SYNC_W-1:0]  sync_cnt_i,
    input  logic [IVL_W-1:0]   ivl_i,
    input  logic               full_i,
    output logic               push_o,
    output logic [REC_W-1:0]   rec_o,
    output logic               ovf_o
);

    localparam logic [PLANE_W:0] CAP_LIM = (PLANE_W + 1)'(CAP_PLANES);

    logic              qual;
    logic [SYNC_W-1:0] frame_val;
    logic [IVL_W-1:0]  offset_val;
    logic              ovf_q;

    // Strobe qualification against the captured plane range.
    always_comb begin
        qual = strobe_i && ({1'b0, plane_i} < CAP_LIM);
    end

    // Field selection: a same-cycle sync wins over the held counters.
    always_comb begin
        if (sync_i) begin
            frame_val  = sync_cnt_i + 1'b1;
            offset_val = '0;
        end else begin
            frame_val  = sync_cnt_i;
            offset_val = ivl_i;
        end
    end

    // Record packing and push decision.
    always_comb begin
        rec_o  = {plane_i, frame_val, offset_val};
        push_o = qual && !full_i;
    end

    // Sticky overflow: set by any capture that meets a full buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (qual && full_i) begin
            ovf_q <= 1'b1;
        end
    end

    assign ovf_o = ovf_q;

endmodule

// File: rtl/stamp_fifo.sv
// Module: stamp_fifo
// Show-ahead record buffer with full and empty flags. A read while empty
// is ignored.
// Assumes: DEPTH is a power of two; push_i is never high while full.
module stamp_fifo #(
    parameter int unsigned DATA_W = 35,
    parameter int unsigned DEPTH  = stamp_pkg::DEF_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              empty_o,
    output logic              full_o
);

    import stamp_pkg::*;

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     count;
    logic              pop;
    buf_op_e           op;

    // Occupancy flags and the effective pop.
    always_comb begin
        empty_o = (count == '0);
        full_o  = (count == CNT_FULL);
        pop     = rd_en_i && !empty_o;
        op      = buf_op_e'({pop, push_i});
    end

    // Storage entries: each is written only when selected by the write pointer.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (push_i && (wr_ptr == AW'(g))) begin
                mem[g] <= wdata_i;
            end
        end
    end

    // Pointer and occupancy update by the selected operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            case (op)
                OP_PUSH: begin
                    wr_ptr <= wr_ptr + 1'b1;
                    count  <= count + 1'b1;
                end
                OP_POP: begin
                    rd_ptr <= rd_ptr + 1'b1;
                    count  <= count - 1'b1;
                end
                OP_BOTH: begin
                    wr_ptr <= wr_ptr + 1'b1;
                    rd_ptr <= rd_ptr + 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    assign rdata_o = mem[rd_ptr];

endmodule

// File: rtl/plane_reset_stamper.sv
// Module: plane_reset_stamper (top)
// Stamps each low-order bit-plane reset command with (frame, offset since
// sync, plane) and buffers the stamps for readout.
// Assumes: all inputs synchronous to clk; sync_i pulses are one clock wide.
module plane_reset_stamper #(
    parameter int unsigned SYNC_W     = stamp_pkg::DEF_SYNC_W,
    parameter int unsigned IVL_W      = stamp_pkg::DEF_IVL_W,
    parameter int unsigned PRESCALE   = stamp_pkg::DEF_PRESCALE,
    parameter int unsigned PLANE_W    = stamp_pkg::DEF_PLANE_W,
    parameter int unsigned DEPTH      = stamp_pkg::DEF_DEPTH,
    parameter int unsigned CAP_PLANES = stamp_pkg::DEF_CAP_PLANES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_i,
    input  logic               rst_strobe_i,
    input  logic [PLANE_W-1:0] plane_i,
    input  logic               rd_en_i,
    output logic [SYNC_W-1:0]  rd_frame_o,
    output logic [IVL_W-1:0]   rd_offset_o,
    output logic [PLANE_W-1:0] rd_plane_o,
    output logic               empty_o,
    output logic               full_o,
    output logic               overflow_o
);

    localparam int unsigned REC_W = SYNC_W + IVL_W + PLANE_W;

    logic [SYNC_W-1:0] sync_cnt;
    logic [IVL_W-1:0]  ivl_cnt;
    logic              push;
    logic [REC_W-1:0]  rec_in;
    logic [REC_W-1:0]  rec_out;

    stamp_timebase #(
        .SYNC_W   (SYNC_W),
        .IVL_W    (IVL_W),
        .PRESCALE (PRESCALE)
    ) u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_i     (sync_i),
        .sync_cnt_o (sync_cnt),
        .ivl_o      (ivl_cnt)
    );

    stamp_capture #(
        .SYNC_W     (SYNC_W),
        .IVL_W      (IVL_W),
        .PLANE_W    (PLANE_W),
        .CAP_PLANES (CAP_PLANES)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_i     (sync_i),
        .strobe_i   (rst_strobe_i),
        .plane_i    (plane_i),
        .sync_cnt_i (sync_cnt),
        .ivl_i      (ivl_cnt),
        .full_i     (full_o),
        .push_o     (push),
        .rec_o      (rec_in),
        .ovf_o      (overflow_o)
    );

    stamp_fifo #(
        .DATA_W (REC_W),
        .DEPTH  (DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .wdata_i (rec_in),
        .rd_en_i (rd_en_i),
        .rdata_o (rec_out),
        .empty_o (empty_o),
        .full_o  (full_o)
    );

    // Unpack the oldest record into its fields.
    always_comb begin
        {rd_plane_o, rd_frame_o, rd_offset_o} = rec_out;
    end

endmodule

// File: rtl/stamp_checker.sv
// Module: stamp_checker
// Temporal properties of the recorder. Attached to the top with bind.
module stamp_checker #(
    parameter int unsigned SYNC_W     = 16,
    parameter int unsigned IVL_W      = 16,
    parameter int unsigned PLANE_W    = 3,
    parameter int unsigned CAP_PLANES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sync_i,
    input logic               rst_strobe_i,
    input logic [PLANE_W-1:0] plane_i,
    input logic               rd_en_i,
    input logic               empty_o,
    input logic               full_o,
    input logic               overflow_o,
    input logic [SYNC_W-1:0]  sync_cnt,
    input logic [IVL_W-1:0]   ivl_cnt
);

    localparam logic [IVL_W-1:0] IVL_TOP = '1;
    localparam logic [PLANE_W:0] LIM     = (PLANE_W + 1)'(CAP_PLANES);

    logic cap_req;
    always_comb begin
        cap_req = rst_strobe_i && ({1'b0, plane_i} < LIM);
    end

    // R1: the flags are never contradictory.
    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty_o && full_o));

    // R2: each sync advances the frame count by one.
    a_r2_sync_advances: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (sync_cnt == SYNC_W'($past(sync_cnt) + 1'b1)));

    // R3: the interval count restarts after a sync.
    a_r3_interval_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (ivl_cnt == '0));

    // R4: a saturated interval count holds until a sync.
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ((ivl_cnt == IVL_TOP) && !sync_i) |=> (ivl_cnt == IVL_TOP));

    // R5 and R9: no capture and an empty buffer keep it empty, reads included.
    a_r9_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && !cap_req) |=> empty_o);

    // R8: overflow is sticky.
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);

    // R8: overflow rises only after a capture met a full buffer.
    a_r8_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow_o) |-> $past(full_o && cap_req));

    // R8: a full buffer with no read stays full.
    a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !rd_en_i) |=> full_o);

endmodule

bind plane_reset_stamper stamp_checker #(
    .SYNC_W     (SYNC_W),
    .IVL_W      (IVL_W),
    .PLANE_W    (PLANE_W),
    .CAP_PLANES (CAP_PLANES)
) u_stamp_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_i       (sync_i),
    .rst_strobe_i (rst_strobe_i),
    .plane_i      (plane_i),
    .rd_en_i      (rd_en_i),
    .empty_o      (empty_o),
    .full_o       (full_o),
    .overflow_o   (overflow_o),
    .sync_cnt     (sync_cnt),
    .ivl_cnt      (ivl_cnt)
);

// File: tb/plane_reset_stamper_test.sv
`timescale 1ns/1ps
module plane_reset_stamper_test;

    localparam int SW = 8;
    localparam int IW = 6;
    localparam int PS = 3;
    localparam int PW = 3;
    localparam int DP = 8;
    localparam int CP = 4;
    localparam int IMAX = (1 << IW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_i = 1'b0;
    logic          rst_strobe_i = 1'b0;
    logic [PW-1:0] plane_i = '0;
    logic          rd_en_i = 1'b0;
    logic [SW-1:0] rd_frame_o;
    logic [IW-1:0] rd_offset_o;
    logic [PW-1:0] rd_plane_o;
    logic          empty_o, full_o, overflow_o;

    plane_reset_stamper #(
        .SYNC_W(SW), .IVL_W(IW), .PRESCALE(PS),
        .PLANE_W(PW), .DEPTH(DP), .CAP_PLANES(CP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i),
        .rst_strobe_i(rst_strobe_i), .plane_i(plane_i), .rd_en_i(rd_en_i),
        .rd_frame_o(rd_frame_o), .rd_offset_o(rd_offset_o),
        .rd_plane_o(rd_plane_o), .empty_o(empty_o), .full_o(full_o),
        .overflow_o(overflow_o)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int nsync  = 0;
    int pops;
    bit done = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model state.
    int qf[$];
    int qo[$];
    int qp[$];
    int m_sync = 0;
    int m_c    = 0;
    bit m_ovf  = 0;
    bit live   = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            qf.delete(); qo.delete(); qp.delete();
            m_sync = 0; m_c = 0; m_ovf = 0; live = 1;
        end else begin
            bit cap, was_full;
            int fr, off;
            cap = rst_strobe_i && (int'(plane_i) < CP);
            fr  = (m_sync + (sync_i ? 1 : 0)) % (1 << SW);
            off = sync_i ? 0 : ((m_c / PS) > IMAX ? IMAX : (m_c / PS));
            was_full = (qf.size() == DP);
            if (rd_en_i && qf.size() > 0) begin
                void'(qf.pop_front()); void'(qo.pop_front()); void'(qp.pop_front());
            end
            if (cap && !was_full) begin
                qf.push_back(fr); qo.push_back(off); qp.push_back(int'(plane_i));
            end
            if (cap && was_full) m_ovf = 1;
            if (sync_i) begin
                m_sync = m_sync + 1; m_c = 0;
            end else if (m_c < 100000) begin
                m_c = m_c + 1;
            end
        end
        #1;
        if (live) begin
            chk("R9 empty flag", empty_o, qf.size() == 0);
            chk("R8 full flag", full_o, qf.size() == DP);
            chk("R8 overflow flag", overflow_o, m_ovf);
            if (qf.size() > 0) begin
                chk("R2 frame field", rd_frame_o, qf[0]);
                chk("R3 offset field", rd_offset_o, qo[0]);
                chk("R6 plane field", rd_plane_o, qp[0]);
            end
        end
    end

    // Stimulus tasks: each is entered right after a falling edge.
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sync();
        sync_i = 1'b1; nsync++;
        @(negedge clk);
        sync_i = 1'b0;
    endtask

    task automatic strobe(input int p);
        rst_strobe_i = 1'b1; plane_i = PW'(p);
        @(negedge clk);
        rst_strobe_i = 1'b0;
    endtask

    task automatic drain();
        pops = 0;
        while (!empty_o) begin
            rd_en_i = 1'b1; pops++;
            @(negedge clk);
        end
        rd_en_i = 1'b0;
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 empty after reset", empty_o, 1);
        chk("R1 full after reset", full_o, 0);
        chk("R1 overflow after reset", overflow_o, 0);

        // Capture before any sync: frame 0.
        idle(10);
        strobe(0);
        chk("R2 frame before sync", rd_frame_o, 0);
        drain();

        // R3 directed: strobe 10 clocks after the sync edge -> offset 3.
        pulse_sync();
        idle(9);
        strobe(1);
        chk("R3 offset after 10 clocks", rd_offset_o, 3);
        chk("R2 frame after one sync", rd_frame_o, nsync);
        chk("R6 plane stored", rd_plane_o, 1);
        drain();

        // R5: planes at or above the limit are ignored.
        strobe(4);
        strobe(7);
        chk("R5 high planes store nothing", empty_o, 1);

        // R7: sync and strobe on the same edge.
        sync_i = 1'b1; nsync++; rst_strobe_i = 1'b1; plane_i = 3'd2;
        @(negedge clk);
        sync_i = 1'b0; rst_strobe_i = 1'b0;
        chk("R7 same-cycle frame", rd_frame_o, nsync);
        chk("R7 same-cycle offset", rd_offset_o, 0);
        chk("R7 same-cycle plane", rd_plane_o, 2);
        drain();

        // R2: several syncs in a row.
        for (int i = 0; i < 5; i++) begin
            pulse_sync();
            idle(2);
        end
        strobe(3);
        chk("R2 frame after burst", rd_frame_o, nsync);
        drain();

        // R4: saturation of the interval count.
        pulse_sync();
        idle(250);
        strobe(0);
        chk("R4 saturated offset", rd_offset_o, IMAX);
        drain();

        // R9: reads on an empty buffer, then read plus write together.
        rd_en_i = 1'b1;
        idle(3);
        rd_en_i = 1'b0;
        chk("R9 empty read ignored", empty_o, 1);
        strobe(1);
        rd_en_i = 1'b1; rst_strobe_i = 1'b1; plane_i = 3'd2;
        @(negedge clk);
        rd_en_i = 1'b0; rst_strobe_i = 1'b0;
        chk("R9 read+write keeps one", rd_plane_o, 2);
        drain();
        chk("R9 one pop drains", pops, 1);

        // R8: fill, then overflow.
        pulse_sync();
        for (int i = 0; i < DP; i++) begin
            strobe(i % CP);
        end
        chk("R8 full after depth", full_o, 1);
        chk("R8 no overflow yet", overflow_o, 0);
        strobe(3);
        chk("R8 overflow set", overflow_o, 1);
        chk("R8 oldest kept", rd_plane_o, 0);

        // R10: capture and read while full.
        rd_en_i = 1'b1; rst_strobe_i = 1'b1; plane_i = 3'd1;
        @(negedge clk);
        rd_en_i = 1'b0; rst_strobe_i = 1'b0;
        chk("R10 full cleared by read", full_o, 0);
        drain();
        chk("R10 capture dropped", pops, DP - 1);
        chk("R8 overflow sticky", overflow_o, 1);

        idle(3);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule